// File: doc/BRIEF.md
# Power-Budgeted Self-Test Session Controller

This block sequences a fixed set of on-chip self-tests through a list of sessions. Every test has a constant run length in clock cycles and a power weight. The tests grouped into one session run side by side. The session list is written so that the summed weight of the tests running together stays within a peak budget. The pattern generators and signature compactors are not part of this block: each one is represented only by the enable line the controller drives for it.

A start pulse loads the first session. Each test in that session gets its own down-counter, and a test's enable falls as soon as its own count runs out. The shorter tests in a session therefore stop early, while the longest one sets how long the session lasts. When that longest test finishes, the next session is loaded in the very next cycle, so no idle cycle sits between sessions. When the list is exhausted, a one-cycle done pulse follows and the total number of run cycles is held on an output.

Alongside the sequencing, the block reports the summed weight of the enabled tests in every cycle. It keeps a sticky flag that records any cycle in which that sum went above the budget. The default table runs three sessions: tests 3 and 4 first, then tests 2 and 5, then tests 1 and 6. This takes 120 cycles and never draws more than 3 units against a budget of 4.

Top module: `bist_session_ctrl`

## Requirements
- R1: After reset all enables are low, power_o is 0, session_o is 0, cycles_o is 0, and busy_o, done_o and overrun_o are low.
- R2: A start_i high while idle is sampled at a clock edge, and from that edge on the enables are those of table entry 0. Bit i of an entry's mask enables test i+1, so bit 0 is test 1.
- R3: Each enabled test stays high for exactly its own length in cycles, counted from the edge that loaded its session, and then drops on its own. For example, test 4 drops after 5 cycles while test 3 runs for 10.
- R4: The next table entry is loaded at the edge where the longest test of the current session ends, with no gap cycle. session_o gives the index of the loaded entry.
- R5: The list ends at the first all-zero mask, or after the last table entry when every entry is in use.
- R6: busy_o is high while sessions run. At the edge that ends the last session, busy_o falls and done_o rises for exactly one cycle.
- R7: cycles_o is cleared at the start edge and grows by one per running cycle, so it reads j after the j-th edge following start. It holds its final value (120 for the default table) once the run ends.
- R8: power_o equals the sum of the weights of the tests whose enables are high in the same cycle. The weights for tests 1 to 6 are 2, 1, 1, 1, 2, 1.
- R9: overrun_o rises one cycle after power_o first exceeds PMAX (4) and stays high until reset.
- R10: A start_i pulse that arrives while a run is in progress has no effect on the enables, the session index or the cycle count.
- R11: A start_i after a completed run replays the list from entry 0, with cycles_o cleared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins the session list when idle |
| test_en_o | output | NUM_TESTS (6) | One enable per test, bit 0 = test 1 |
| session_o | output | SES_W (2) | Index of the loaded table entry |
| power_o | output | SUM_W (6) | Summed weight of the enabled tests |
| overrun_o | output | 1 | Sticky flag: the budget was exceeded |
| busy_o | output | 1 | Sessions are running |
| done_o | output | 1 | One-cycle pulse after the last session |
| cycles_o | output | CYC_W (16) | Running cycles of the current or last run |

## Verification
Every result here follows one register stage after its cause. The enables, the session index, the power sum and the cycle count all reflect the start edge in the cycle just after it. The next session appears at the same edge where the longest current test drops. overrun_o lags the offending power sum by one cycle, and done_o appears in the cycle after the final enable falls. The bench drives start_i at a falling edge and then re-samples every output at each following falling edge. At offset j it compares against a model that walks its own copy of the lengths, weights and masks. Spot checks of the overrun flag and of the end of the list are placed at the exact offsets this one-stage rule predicts.

// File: rtl/bist_sched_pkg.sv
package bist_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sched_state_e;

endpackage

// File: rtl/bist_test_lane.sv
// One test slot: a down-counter that holds the remaining cycles of its test.
module bist_test_lane #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             en_o,
    output logic             ending_o
);

    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign en_o     = (cnt_q != '0);
    // Lane is idle after the coming edge unless it is reloaded.
    assign ending_o = (cnt_q <= LEN_W'(1));

endmodule

// File: rtl/bist_power_sum.sv
// Adds the weights of every enabled test.
module bist_power_sum #(
    parameter int                           NUM_TESTS = 6,
    parameter int                           PWR_W     = 3,
    parameter int                           SUM_W     = 6,
    parameter logic [NUM_TESTS*PWR_W-1:0]   TEST_PWR  = '0
) (
    input  logic [NUM_TESTS-1:0] en_i,
    output logic [SUM_W-1:0]     sum_o
);

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < NUM_TESTS; i++) begin
            if (en_i[i]) begin
                sum_o = sum_o + SUM_W'(TEST_PWR[i*PWR_W +: PWR_W]);
            end
        end
    end

endmodule

// File: rtl/bist_session_ctrl.sv
module bist_session_ctrl
    import bist_sched_pkg::*;
#(
    parameter int NUM_TESTS = 6,
    parameter int NUM_SESS  = 4,
    parameter int LEN_W     = 8,
    parameter int PWR_W     = 3,
    parameter int CYC_W     = 16,
    parameter int PMAX      = 4,
    // Test 1 in the lowest slice.
    parameter logic [NUM_TESTS*LEN_W-1:0]    TEST_LEN  =
        {8'd100, 8'd10, 8'd5, 8'd10, 8'd10, 8'd100},
    parameter logic [NUM_TESTS*PWR_W-1:0]    TEST_PWR  =
        {3'd1, 3'd2, 3'd1, 3'd1, 3'd1, 3'd2},
    // Entry 0 in the lowest slice; an all-zero mask ends the list.
    parameter logic [NUM_SESS*NUM_TESTS-1:0] SESS_MASK =
        {6'b000000, 6'b100001, 6'b010010, 6'b001100},
    localparam int SES_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1,
    localparam int SUM_W = PWR_W + $clog2(NUM_TESTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic [NUM_TESTS-1:0] test_en_o,
    output logic [SES_W-1:0]     session_o,
    output logic [SUM_W-1:0]     power_o,
    output logic                 overrun_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [CYC_W-1:0]     cycles_o
);

    typedef struct packed {
        sched_state_e     state;
        logic [SES_W-1:0] sess;
        logic [CYC_W-1:0] cyc;
        logic             ovr;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_TESTS-1:0] lane_en;
    logic [NUM_TESTS-1:0] lane_ending;
    logic [NUM_TESTS-1:0] load_vec;
    logic [SUM_W-1:0]     power_sum;

    function automatic logic [NUM_TESTS-1:0] entry_mask(input int idx);
        if (idx < NUM_SESS) begin
            return SESS_MASK[idx*NUM_TESTS +: NUM_TESTS];
        end
        return '0;
    endfunction

    always_comb begin
        int nxt;
        logic [NUM_TESTS-1:0] nxt_mask;
        ctrl_d   = ctrl_q;
        load_vec = '0;
        nxt      = int'(ctrl_q.sess) + 1;
        nxt_mask = entry_mask(nxt);

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.cyc  = '0;
                    ctrl_d.sess = '0;
                    if (entry_mask(0) != '0) begin
                        ctrl_d.state = ST_RUN;
                        load_vec     = entry_mask(0);
                    end else begin
                        ctrl_d.state = ST_FIN;
                    end
                end
            end
            ST_RUN: begin
                ctrl_d.cyc = ctrl_q.cyc + CYC_W'(1);
                if (&lane_ending) begin
                    if (nxt_mask != '0) begin
                        ctrl_d.sess = SES_W'(nxt);
                        load_vec    = nxt_mask;
                    end else begin
                        ctrl_d.state = ST_FIN;
                    end
                end
            end
            ST_FIN: begin
                ctrl_d.state = ST_IDLE;
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase

        if (power_sum > SUM_W'(PMAX)) begin
            ctrl_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, sess: '0, cyc: '0, ovr: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar g = 0; g < NUM_TESTS; g++) begin : g_lane
        bist_test_lane #(.LEN_W(LEN_W)) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_vec[g]),
            .len_i    (TEST_LEN[g*LEN_W +: LEN_W]),
            .en_o     (lane_en[g]),
            .ending_o (lane_ending[g])
        );
    end

    bist_power_sum #(
        .NUM_TESTS (NUM_TESTS),
        .PWR_W     (PWR_W),
        .SUM_W     (SUM_W),
        .TEST_PWR  (TEST_PWR)
    ) i_power (
        .en_i  (lane_en),
        .sum_o (power_sum)
    );

    assign test_en_o = lane_en;
    assign session_o = ctrl_q.sess;
    assign power_o   = power_sum;
    assign overrun_o = ctrl_q.ovr;
    assign busy_o    = (ctrl_q.state == ST_RUN);
    assign done_o    = (ctrl_q.state == ST_FIN);
    assign cycles_o  = ctrl_q.cyc;

endmodule

// File: rtl/bist_session_ctrl_chk.sv
module bist_session_ctrl_chk #(
    parameter int NUM_TESTS = 6,
    parameter int SUM_W     = 6,
    parameter int CYC_W     = 16,
    parameter int PMAX      = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic [NUM_TESTS-1:0] test_en_o,
    input logic [SUM_W-1:0]     power_o,
    input logic                 overrun_o,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [CYC_W-1:0]     cycles_o
);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_en_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en_o != '0) |-> busy_o);

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (power_o > SUM_W'(PMAX)) |=> overrun_o);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_cycles_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(cycles_o));

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

endmodule

bind bist_session_ctrl bist_session_ctrl_chk #(
    .NUM_TESTS (NUM_TESTS),
    .SUM_W     (SUM_W),
    .CYC_W     (CYC_W),
    .PMAX      (PMAX)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .test_en_o (test_en_o),
    .power_o   (power_o),
    .overrun_o (overrun_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cycles_o  (cycles_o)
);

// File: tb/test_bist_session_ctrl.sv
`timescale 1ns/1ps
module test_bist_session_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0;
    logic start_b = 1'b0;
    int   n_run = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    // Bench copy of the default schedule (test 1 at index 0).
    localparam int TL [6] = '{100, 10, 10, 5, 10, 100};
    localparam int TP [6] = '{2, 1, 1, 1, 2, 1};
    localparam logic [5:0] SM [4] = '{6'b001100, 6'b010010, 6'b100001, 6'b000000};

    logic [5:0]  en_a, en_b;
    logic [1:0]  ses_a;
    logic        ses_b;
    logic [5:0]  pw_a, pw_b;
    logic        ovr_a, ovr_b, busy_a, busy_b, done_a, done_b;
    logic [15:0] cyc_a, cyc_b;

    bist_session_ctrl i_bist_session_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_a),
        .test_en_o(en_a), .session_o(ses_a), .power_o(pw_a),
        .overrun_o(ovr_a), .busy_o(busy_a), .done_o(done_a), .cycles_o(cyc_a)
    );

    // Over-budget table filling every entry: {T1,T5,T6} then {T2}.
    bist_session_ctrl #(
        .NUM_SESS  (2),
        .SESS_MASK ({6'b000010, 6'b110001})
    ) i_bist_session_ctrl_ovr (
        .clk(clk), .rst_n(rst_n), .start_i(start_b),
        .test_en_o(en_b), .session_o(ses_b), .power_o(pw_b),
        .overrun_o(ovr_b), .busy_o(busy_b), .done_o(done_b), .cycles_o(cyc_b)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] model_en(input int j);
        int off = 0;
        logic [5:0] r = '0;
        for (int s = 0; s < 4; s++) begin
            int slen = 0;
            if (SM[s] == '0) break;
            for (int i = 0; i < 6; i++) begin
                if (SM[s][i]) begin
                    if (TL[i] > slen) slen = TL[i];
                    if (j >= off && j < off + TL[i]) r[i] = 1'b1;
                end
            end
            off += slen;
        end
        return r;
    endfunction

    function automatic int model_sess(input int j);
        int off = 0;
        int last = 0;
        for (int s = 0; s < 4; s++) begin
            int slen = 0;
            if (SM[s] == '0) break;
            for (int i = 0; i < 6; i++)
                if (SM[s][i] && TL[i] > slen) slen = TL[i];
            if (j >= off) last = s;
            off += slen;
        end
        return last;
    endfunction

    function automatic int model_pow(input logic [5:0] e);
        int p = 0;
        for (int i = 0; i < 6; i++) if (e[i]) p += TP[i];
        return p;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        chk("R1 enables", en_a, 0);
        chk("R1 power", pw_a, 0);
        chk("R1 session", ses_a, 0);
        chk("R1 cycles", cyc_a, 0);
        chk("R1 busy", busy_a, 0);
        chk("R1 done", done_a, 0);
        chk("R1 overrun", ovr_a, 0);
        chk("R1 overrun second unit", ovr_b, 0);
    endtask

    task automatic run_default(input bit poke, input bit again);
        logic [5:0] e;
        @(negedge clk) start_a = 1'b1;
        @(negedge clk) start_a = 1'b0;
        for (int j = 0; j < 120; j++) begin
            e = model_en(j);
            if (j == 0) chk("R2 first entry enables", en_a, e);
            else        chk("R3 per-test enables", en_a, e);
            chk("R4 session index", ses_a, model_sess(j));
            chk("R8 power sum", pw_a, model_pow(e));
            chk("R7 cycle count", cyc_a, j);
            chk("R6 busy while running", busy_a, 1);
            if (again && j == 0) chk("R11 cycles cleared on restart", cyc_a, 0);
            if (poke && j >= 52 && j <= 54) chk("R10 start ignored", cyc_a, j);
            if (poke && j == 50) start_a = 1'b1;
            if (poke && j == 51) start_a = 1'b0;
            @(negedge clk);
        end
        chk("R6 done pulse", done_a, 1);
        chk("R6 busy falls", busy_a, 0);
        chk("R5 list ends at zero mask", en_a, 0);
        chk("R7 final count", cyc_a, 120);
        @(negedge clk);
        chk("R6 done one cycle", done_a, 0);
        chk("R7 count holds", cyc_a, 120);
        chk("R9 no overrun on legal table", ovr_a, 0);
    endtask

    task automatic run_overrun();
        chk("R9 overrun low before run", ovr_b, 0);
        @(negedge clk) start_b = 1'b1;
        @(negedge clk) start_b = 1'b0;
        for (int j = 0; j < 110; j++) begin
            if (j == 0) begin
                chk("R8 power over budget", pw_b, 5);
                chk("R9 overrun not yet", ovr_b, 0);
            end
            if (j == 1) chk("R9 overrun set", ovr_b, 1);
            if (j == 100) begin
                chk("R5 last table entry loaded", ses_b, 1);
                chk("R5 last entry enables", en_b, 6'b000010);
            end
            @(negedge clk);
        end
        chk("R5 ends after last entry", done_b, 1);
        chk("R5 enables off", en_b, 0);
        chk("R7 count over-budget table", cyc_b, 110);
        repeat (3) @(negedge clk);
        chk("R9 overrun sticky", ovr_b, 1);
        do_reset();
        chk("R9 overrun cleared by reset", ovr_b, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check_reset_state();
        run_default(1'b0, 1'b0);
        run_default(1'b1, 1'b1);
        run_overrun();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule